// File: doc/BRIEF.md
# Wakeup-Select Issue Queue

This block holds decoded operations in a small pool of slots until their source operands are available, then hands the oldest ready ones to the execution ports. Each slot keeps two source register tags and one destination tag. Each source tag has its own ready flag. When a slot is granted to a port, its destination tag goes back to every slot in the same cycle. Slots whose sources match the tag mark those operands ready. A dependent operation can then be granted in the very next cycle, so single-cycle producers and their consumers run back to back.

Producers whose latency is not fixed do not wake their consumers at grant time. Their results are announced later on a separate writeback tag bus, which wakes matching operands in the same way. The block tracks only tags and readiness. It does not move operand data.

The front end writes one operation per cycle into the lowest-numbered free slot. It is held off while every slot is occupied.

Top module: `issue_sched`

## Requirements
- R1: During reset and in the first cycle after it, no port reports a grant and `disp_ready` is high.
- R2: A slot is granted only while it is occupied and both of its operands are ready. An operand is ready at dispatch when its ready input is 1 or its tag is 0.
- R3: When an operation of class 0 is granted, its destination tag wakes every matching operand, both in occupied slots and in an operation dispatched in that same cycle. Such a dependent is granted in the next cycle.
- R4: At most W slots are granted per cycle, and no slot appears on two ports in one cycle.
- R5: Among ready slots, the grants go in dispatch order: port 0 gets the oldest, port 1 the next oldest, and so on. A port above 0 is used only if every lower port is used.
- R6: A granted slot is free from the following cycle. It is never granted twice for one dispatch, and it can take a new dispatch from that cycle on.
- R7: `disp_ready` is low while all slots are occupied. A dispatch presented in that state is discarded.
- R8: Granting an operation of a class other than 0 wakes no operand.
- R9: A valid writeback tag wakes matching operands, both in occupied slots and in an operation dispatched in the same cycle.
- R10: Take a graph in which op1 feeds ops 2, 3 and 4, and ops 2 and 3 each feed ops 5 and 6, with two ports. Once op1 is ready, the grants over four cycles are {1}, {2,3}, {4,5}, {6}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | An operation is offered for dispatch |
| disp_ready | output | 1 | At least one slot is free |
| disp_src_l | input | TAG_W | Left source tag |
| disp_rdy_l | input | 1 | Left source is already available |
| disp_src_r | input | TAG_W | Right source tag |
| disp_rdy_r | input | 1 | Right source is already available |
| disp_dst | input | TAG_W | Destination tag |
| disp_cls | input | CLS_W | Operation class; 0 means a fixed single-cycle latency |
| wb_valid | input | 1 | Writeback tag bus carries a tag |
| wb_tag | input | TAG_W | Tag of a completed variable-latency result |
| iss_valid | output | W | Per-port grant |
| iss_idx | output | W*IDX_W | Per-port granted slot index |
| iss_dst | output | W*TAG_W | Per-port destination tag of the granted slot |
| iss_cls | output | W*CLS_W | Per-port class of the granted slot |

## Verification
The properties assume two things about the front end. First, destination tags that are in flight at the same time are distinct. Second, no slot waits longer than half the span of the age counter while newer operations pass it, because beyond that the relative age comparison wraps. The bench keeps within both limits. Every destination tag it uses is unique within a scenario, and each run has only a few dozen dispatches against a 256-value age counter. All inputs change mid-cycle, and grants are read before new stimulus is applied.

// File: rtl/iq_pkg.sv
package iq_pkg;

   // operation class whose result is available one cycle after grant
   localparam int unsigned FIXED_LAT_CLASS = 0;

   // true when sequence a was assigned before sequence b (modulo 2**w)
   function automatic logic seq_before(input logic [31:0] a,
                                       input logic [31:0] b,
                                       input int unsigned w);
      logic [31:0] diff;
      diff = a - b;
      return diff[w-1];
   endfunction

endpackage

// File: rtl/iq_alloc.sv
module iq_alloc #(
   parameter int unsigned N = 8
) (
   input  logic [N-1:0] slot_busy,
   output logic [N-1:0] free_oh,
   output logic         free_any
);
   always_comb begin : p_pick
      logic found;
      found   = 1'b0;
      free_oh = '0;
      for (int i = 0; i < N; i++) begin
         if (!slot_busy[i] && !found) begin
            free_oh[i] = 1'b1;
            found      = 1'b1;
         end
      end
      free_any = found;
   end
endmodule

// File: rtl/iq_slot.sv
module iq_slot #(
   parameter int unsigned W     = 2,
   parameter int unsigned TAG_W = 6,
   parameter int unsigned CLS_W = 2,
   parameter int unsigned SEQ_W = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [TAG_W-1:0]   wr_src_l,
   input  logic               wr_rdy_l,
   input  logic [TAG_W-1:0]   wr_src_r,
   input  logic               wr_rdy_r,
   input  logic [TAG_W-1:0]   wr_dst,
   input  logic [CLS_W-1:0]   wr_cls,
   input  logic [SEQ_W-1:0]   wr_seq,
   input  logic               granted,
   input  logic [W-1:0]       bc_valid,
   input  logic [W*TAG_W-1:0] bc_tag,
   input  logic               wb_valid,
   input  logic [TAG_W-1:0]   wb_tag,
   output logic               busy,
   output logic               req,
   output logic [TAG_W-1:0]   dst,
   output logic [CLS_W-1:0]   cls,
   output logic [SEQ_W-1:0]   seq
);
   logic [TAG_W-1:0] src_l_q, src_r_q;
   logic             rdy_l_q, rdy_r_q;
   logic             hit_l, hit_r, hit_wl, hit_wr;

   function automatic logic snoop(input logic [TAG_W-1:0] t);
      logic m;
      m = wb_valid && (wb_tag == t);
      for (int k = 0; k < W; k++)
         m = m | (bc_valid[k] && (bc_tag[k*TAG_W +: TAG_W] == t));
      return m;
   endfunction

   always_comb begin
      hit_l  = snoop(src_l_q);
      hit_r  = snoop(src_r_q);
      hit_wl = snoop(wr_src_l);
      hit_wr = snoop(wr_src_r);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         rdy_l_q <= 1'b0;
         rdy_r_q <= 1'b0;
         src_l_q <= '0;
         src_r_q <= '0;
         dst     <= '0;
         cls     <= '0;
         seq     <= '0;
      end else if (wr_en) begin
         busy    <= 1'b1;
         src_l_q <= wr_src_l;
         src_r_q <= wr_src_r;
         rdy_l_q <= wr_rdy_l | (wr_src_l == '0) | hit_wl;
         rdy_r_q <= wr_rdy_r | (wr_src_r == '0) | hit_wr;
         dst     <= wr_dst;
         cls     <= wr_cls;
         seq     <= wr_seq;
      end else begin
         if (granted) busy <= 1'b0;
         rdy_l_q <= rdy_l_q | hit_l;
         rdy_r_q <= rdy_r_q | hit_r;
      end
   end

   assign req = busy & rdy_l_q & rdy_r_q;
endmodule

// File: rtl/iq_select.sv
module iq_select #(
   parameter int unsigned N     = 8,
   parameter int unsigned W     = 2,
   parameter int unsigned SEQ_W = 8,
   parameter int unsigned IDX_W = 3
) (
   input  logic [N-1:0]       req,
   input  logic [N*SEQ_W-1:0] seq,
   output logic [W-1:0]       gnt_valid,
   output logic [W*IDX_W-1:0] gnt_idx,
   output logic [N-1:0]       gnt_oh
);
   import iq_pkg::*;

   always_comb begin : p_sel
      logic [N-1:0] rem;
      logic         found;
      int           best;
      rem       = req;
      gnt_valid = '0;
      gnt_idx   = '0;
      gnt_oh    = '0;
      for (int p = 0; p < W; p++) begin
         found = 1'b0;
         best  = 0;
         for (int i = 0; i < N; i++) begin
            if (rem[i] && (!found ||
                seq_before(32'(seq[i*SEQ_W +: SEQ_W]),
                           32'(seq[best*SEQ_W +: SEQ_W]), SEQ_W))) begin
               best  = i;
               found = 1'b1;
            end
         end
         if (found) begin
            gnt_valid[p]                 = 1'b1;
            gnt_idx[p*IDX_W +: IDX_W]    = IDX_W'(best);
            gnt_oh[best]                 = 1'b1;
            rem[best]                    = 1'b0;
         end
      end
   end
endmodule

// File: rtl/issue_sched.sv
module issue_sched #(
   parameter int unsigned N     = 8,
   parameter int unsigned W     = 2,
   parameter int unsigned TAG_W = 6,
   parameter int unsigned CLS_W = 2,
   parameter int unsigned SEQ_W = 8,
   localparam int unsigned IDX_W = $clog2(N)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               disp_valid,
   output logic               disp_ready,
   input  logic [TAG_W-1:0]   disp_src_l,
   input  logic               disp_rdy_l,
   input  logic [TAG_W-1:0]   disp_src_r,
   input  logic               disp_rdy_r,
   input  logic [TAG_W-1:0]   disp_dst,
   input  logic [CLS_W-1:0]   disp_cls,
   input  logic               wb_valid,
   input  logic [TAG_W-1:0]   wb_tag,
   output logic [W-1:0]       iss_valid,
   output logic [W*IDX_W-1:0] iss_idx,
   output logic [W*TAG_W-1:0] iss_dst,
   output logic [W*CLS_W-1:0] iss_cls
);
   import iq_pkg::*;

   if (N < 2) begin : g_bad_n
      $error("issue_sched: N must be at least 2");
   end
   if (W < 1 || W > N) begin : g_bad_w
      $error("issue_sched: W must lie in 1..N");
   end
   if (SEQ_W < IDX_W + 2 || SEQ_W > 32) begin : g_bad_seq
      $error("issue_sched: SEQ_W must lie in IDX_W+2..32");
   end

   logic [N-1:0]       ent_valid, ent_req, free_oh, gnt_oh;
   logic               free_any;
   logic [N*TAG_W-1:0] ent_dst;
   logic [N*CLS_W-1:0] ent_cls;
   logic [N*SEQ_W-1:0] ent_seq;
   logic [W-1:0]       bc_valid;
   logic [W*TAG_W-1:0] bc_tag;
   logic [SEQ_W-1:0]   seq_q;
   logic               disp_take;

   assign disp_ready = free_any;
   assign disp_take  = disp_valid & free_any;

   always_ff @(posedge clk) begin
      if (!rst_n)         seq_q <= '0;
      else if (disp_take) seq_q <= seq_q + 1'b1;
   end

   iq_alloc #(.N(N)) u_alloc (
      .slot_busy (ent_valid),
      .free_oh   (free_oh),
      .free_any  (free_any)
   );

   for (genvar i = 0; i < N; i++) begin : g_slot
      iq_slot #(.W(W), .TAG_W(TAG_W), .CLS_W(CLS_W), .SEQ_W(SEQ_W)) u_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (disp_take & free_oh[i]),
         .wr_src_l (disp_src_l),
         .wr_rdy_l (disp_rdy_l),
         .wr_src_r (disp_src_r),
         .wr_rdy_r (disp_rdy_r),
         .wr_dst   (disp_dst),
         .wr_cls   (disp_cls),
         .wr_seq   (seq_q),
         .granted  (gnt_oh[i]),
         .bc_valid (bc_valid),
         .bc_tag   (bc_tag),
         .wb_valid (wb_valid),
         .wb_tag   (wb_tag),
         .busy     (ent_valid[i]),
         .req      (ent_req[i]),
         .dst      (ent_dst[i*TAG_W +: TAG_W]),
         .cls      (ent_cls[i*CLS_W +: CLS_W]),
         .seq      (ent_seq[i*SEQ_W +: SEQ_W])
      );
   end

   iq_select #(.N(N), .W(W), .SEQ_W(SEQ_W), .IDX_W(IDX_W)) u_select (
      .req       (ent_req),
      .seq       (ent_seq),
      .gnt_valid (iss_valid),
      .gnt_idx   (iss_idx),
      .gnt_oh    (gnt_oh)
   );

   // per-port payload and same-cycle tag broadcast
   for (genvar p = 0; p < W; p++) begin : g_port
      logic [IDX_W-1:0] pidx;
      logic [TAG_W-1:0] pdst;
      logic [CLS_W-1:0] pcls;
      assign pidx = iss_idx[p*IDX_W +: IDX_W];
      always_comb begin
         pdst = '0;
         pcls = '0;
         for (int i = 0; i < N; i++) begin
            if (pidx == IDX_W'(i)) begin
               pdst = ent_dst[i*TAG_W +: TAG_W];
               pcls = ent_cls[i*CLS_W +: CLS_W];
            end
         end
      end
      assign iss_dst[p*TAG_W +: TAG_W] = pdst;
      assign iss_cls[p*CLS_W +: CLS_W] = pcls;
      assign bc_valid[p] = iss_valid[p] && (pcls == CLS_W'(FIXED_LAT_CLASS));
      assign bc_tag[p*TAG_W +: TAG_W] = pdst;
   end
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
   parameter int unsigned N     = 8,
   parameter int unsigned W     = 2,
   parameter int unsigned IDX_W = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [W-1:0]       iss_valid,
   input logic [W*IDX_W-1:0] iss_idx,
   input logic [N-1:0]       ent_valid
);
   for (genvar k = 0; k < W; k++) begin : g_k
      // R2: only an occupied slot may be granted
      assert_grant_occupied_R2: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[k] |-> ent_valid[iss_idx[k*IDX_W +: IDX_W]]);

      // R6: a granted slot is empty in the following cycle
      assert_slot_freed_R6: assert property (@(posedge clk) disable iff (!rst_n)
         iss_valid[k] |=> !ent_valid[$past(iss_idx[k*IDX_W +: IDX_W])]);

      if (k > 0) begin : g_pack
         // R5: ports fill from port 0 upward
         assert_ports_packed_R5: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[k] |-> iss_valid[k-1]);
      end

      for (genvar j = 0; j < W; j++) begin : g_j
         if (j < k) begin : g_pair
            // R4: one slot per port in a cycle
            assert_distinct_slots_R4: assert property (@(posedge clk) disable iff (!rst_n)
               (iss_valid[j] && iss_valid[k]) |->
               (iss_idx[j*IDX_W +: IDX_W] != iss_idx[k*IDX_W +: IDX_W]));
         end
         // R6: no second grant of a slot in the cycle after its grant
         assert_no_regrant_R6: assert property (@(posedge clk) disable iff (!rst_n)
            iss_valid[j] |=> !(iss_valid[k] &&
               iss_idx[k*IDX_W +: IDX_W] == $past(iss_idx[j*IDX_W +: IDX_W])));
      end
   end
endmodule

bind issue_sched iq_checker #(.N(N), .W(W), .IDX_W(IDX_W)) u_iq_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_valid (iss_valid),
   .iss_idx   (iss_idx),
   .ent_valid (ent_valid)
);

// File: tb/issue_sched_tb.sv
`timescale 1ns/1ps
module issue_sched_tb;
   localparam int N = 8, W = 2, TAG_W = 6, CLS_W = 2, IDX_W = 3;

   logic clk = 1'b0;
   logic rst_n;
   logic disp_valid, disp_ready, disp_rdy_l, disp_rdy_r, wb_valid;
   logic [TAG_W-1:0] disp_src_l, disp_src_r, disp_dst, wb_tag;
   logic [CLS_W-1:0] disp_cls;
   logic [W-1:0] iss_valid;
   logic [W*IDX_W-1:0] iss_idx;
   logic [W*TAG_W-1:0] iss_dst;
   logic [W*CLS_W-1:0] iss_cls;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 0;

   always #4 clk = ~clk;

   issue_sched #(.N(N), .W(W), .TAG_W(TAG_W), .CLS_W(CLS_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .disp_valid(disp_valid), .disp_ready(disp_ready),
      .disp_src_l(disp_src_l), .disp_rdy_l(disp_rdy_l), .disp_src_r(disp_src_r),
      .disp_rdy_r(disp_rdy_r), .disp_dst(disp_dst), .disp_cls(disp_cls),
      .wb_valid(wb_valid), .wb_tag(wb_tag), .iss_valid(iss_valid),
      .iss_idx(iss_idx), .iss_dst(iss_dst), .iss_cls(iss_cls));

   task automatic chk(input string r, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_errs++;
         $display("FAIL %s: got %0d expected %0d", r, act, exp);
      end
   endtask

   // expected grant count and slot indices on ports 0 and 1
   task automatic chk_iss(input string r, input int cnt, input int e0, input int e1);
      chk({r, " grant count"}, int'(iss_valid[0]) + int'(iss_valid[1]), cnt);
      if (cnt >= 1) chk({r, " port0 slot"}, int'(iss_idx[IDX_W-1:0]), e0);
      if (cnt >= 2) chk({r, " port1 slot"}, int'(iss_idx[2*IDX_W-1:IDX_W]), e1);
   endtask

   task automatic put(input int sl, input bit rl, input int sr, input bit rr,
                      input int d, input int c);
      disp_valid = 1'b1;
      disp_src_l = TAG_W'(sl); disp_rdy_l = rl;
      disp_src_r = TAG_W'(sr); disp_rdy_r = rr;
      disp_dst   = TAG_W'(d);  disp_cls   = CLS_W'(c);
   endtask

   task automatic quiet();
      disp_valid = 1'b0;
      wb_valid   = 1'b0;
   endtask

   task automatic wb(input int t);
      wb_valid = 1'b1;
      wb_tag   = TAG_W'(t);
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 8);
      n_checks++;
      n_errs++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      rst_n = 1'b0;
      disp_src_l = '0; disp_src_r = '0; disp_dst = '0; disp_cls = '0;
      disp_rdy_l = 1'b0; disp_rdy_r = 1'b0; wb_tag = '0;
      quiet();
      repeat (3) tick();
      chk("R1 reset grants", int'(iss_valid), 0);
      chk("R1 reset disp_ready", int'(disp_ready), 1);
      rst_n = 1'b1;
      tick();
      chk("R1 after reset grants", int'(iss_valid), 0);
      chk("R1 after reset disp_ready", int'(disp_ready), 1);

      // R10 dependence graph: op1 waits on writeback tag 40
      put(40, 0, 0, 1, 11, 0); tick();      // op1 -> slot 0
      put(11, 0, 0, 1, 12, 0); tick();      // op2 -> slot 1
      put(11, 0, 0, 1, 13, 0); tick();      // op3 -> slot 2
      put(0, 1, 11, 0, 14, 0); tick();      // op4 -> slot 3
      put(12, 0, 13, 0, 15, 0); tick();     // op5 -> slot 4
      put(13, 0, 12, 0, 16, 0); tick();     // op6 -> slot 5
      quiet(); chk_iss("R2 all waiting", 0, 0, 0); wb(40); tick();
      quiet(); chk_iss("R10 cycle1", 1, 0, 0);
      chk("R3 broadcast dst", int'(iss_dst[TAG_W-1:0]), 11); tick();
      chk_iss("R10 cycle2", 2, 1, 2); tick();
      chk_iss("R10 cycle3", 2, 3, 4); tick();
      chk_iss("R10 cycle4", 1, 5, 0); tick();
      chk_iss("R6 graph drained", 0, 0, 0);

      // R5/R7 age order against slot order, full-queue behaviour
      for (int i = 0; i < N; i++) begin
         put((i < 2) ? 40 : 50, 0, 0, 1, 20 + i, 0);
         tick();
      end
      quiet(); chk("R7 full disp_ready", int'(disp_ready), 0);
      put(0, 1, 0, 1, 63, 0); tick();       // must be discarded
      quiet(); chk_iss("R7 discarded dispatch", 0, 0, 0); wb(40); tick();
      quiet(); chk_iss("R5 first pair", 2, 0, 1);
      chk("R6 not yet free", int'(disp_ready), 0); tick();
      chk("R6 free next cycle", int'(disp_ready), 1);
      chk_iss("R6 no regrant", 0, 0, 0);
      put(50, 0, 0, 1, 30, 0); tick();      // young op -> slot 0
      chk_iss("R4 quiet", 0, 0, 0);
      put(50, 0, 0, 1, 31, 0); tick();      // young op -> slot 1
      quiet(); chk_iss("R9 before wake", 0, 0, 0); wb(50); tick();
      quiet(); chk_iss("R5 oldest first a", 2, 2, 3); tick();
      chk_iss("R5 oldest first b", 2, 4, 5); tick();
      chk_iss("R4 width limit", 2, 6, 7); tick();
      chk_iss("R5 youngest last", 2, 0, 1); tick();
      chk_iss("R6 age drained", 0, 0, 0);

      // R8 variable-latency producer, R2 tag 0 means available
      put(0, 0, 0, 0, 21, 1); tick();       // P -> slot 0
      chk_iss("R2 tag zero ready", 1, 0, 0);
      chk("R8 class passed", int'(iss_cls[CLS_W-1:0]), 1);
      put(21, 0, 0, 1, 22, 0); tick();      // D -> slot 1
      quiet(); chk_iss("R8 no wake at grant", 0, 0, 0); tick();
      chk_iss("R8 still waiting", 0, 0, 0); wb(21); tick();
      quiet(); chk_iss("R9 writeback wake", 1, 1, 0);
      chk("R9 dst", int'(iss_dst[TAG_W-1:0]), 22); tick();
      chk_iss("R6 once", 0, 0, 0);

      // R3 dispatch in the cycle its parent is granted
      put(0, 1, 0, 1, 25, 0); tick();       // Q -> slot 0
      chk_iss("R3 parent", 1, 0, 0);
      put(25, 0, 25, 0, 26, 0); tick();     // child -> slot 1
      quiet(); chk_iss("R3 back to back", 1, 1, 0); tick();
      chk_iss("R3 drained", 0, 0, 0);

      // R9 writeback in the dispatch cycle
      put(33, 0, 0, 1, 27, 0); wb(33); tick();
      quiet(); chk_iss("R9 dispatch snoop", 1, 0, 0); tick();
      chk_iss("R9 drained", 0, 0, 0);

      finish_run();
   end
endmodule